// File: doc/BRIEF.md
# Fuse Array Word Read Sequencer

This block reads a one-time-programmable fuse array one 32-bit word at a time, and the hardware drives the whole access. Software uses a small register bus. It picks automatic or user mode, sets a start/end cycle window for each of the five macro control lines, and issues a read command that carries a word address. It then collects the result word and a sticky completion flag. While a command runs, a cycle counter that starts at zero sets the level of each control line. A line is high only while the counter is at or above its window start and below its window end.

A second set of five windows, meant for burn timing, can be written and read back. These windows do not affect the pins. Software that wants an arbitrary byte range issues one command per aligned word, then extracts the bytes it needs from the words it read.

Register offsets: mode 0x00 (bit 0 = user mode), command 0x04 (bit 0 = enable, bit 1 = read, word address in bits [15:6]), status 0x08 (bit 0 = finished, write 1 to clear; bit 1 = busy, read-only), result 0x0C. The burn windows sit at 0x28..0x38 and the read windows at 0x3C..0x4C, in the order select, program-enable, load, address-enable, strobe. Each window register holds the start cycle in [31:16] and the end cycle in [15:0].

Top module: `fuse_rd_seq`

## Requirements
- R1: After reset, the mode bit is 1 (user mode) and the status reads 0. All control pins are low. The read windows read back as select/program-enable/load 0x0000000B, address-enable 0x0002000A and strobe 0x00050008, so the strobe lies inside the address window.
- R2: Every window register, burn or read, returns the last value written to it. The burn windows never change the pins.
- R3: A command starts only if all three hold: a write to 0x04 has bits [1:0] = 2'b11, the mode bit is 0, and no command is running. While a command runs, status bit 1 reads 1.
- R4: In the cycle after the command is accepted, the counter is 0, and it rises by one each cycle. Each pin is high exactly while start <= count < end. A window with end <= start never raises its pin.
- R5: For the whole sequence, fuse_addr_o holds the command's word address, taken from bits [15:6].
- R6: Busy clears and status bit 0 sets one cycle after the count reaches the largest read-window end. The flag is therefore first visible largest_end + 1 cycles after the cycle in which the counter is 0.
- R7: The result register captures fuse_data_i in the cycle where the count equals the strobe end.
- R8: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it set.
- R9: A command written while a sequence runs is ignored. The running address, the pins and the completion time do not change.
- R10: In user mode, commands are ignored and all pins stay low. When no sequence runs, all pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational on bus_addr_i) |
| fuse_data_i | input | 32 | Word sensed from the fuse macro |
| fuse_cs_o | output | 1 | Macro select |
| fuse_pgen_o | output | 1 | Program-enable line |
| fuse_load_o | output | 1 | Load line |
| fuse_aen_o | output | 1 | Address-enable line |
| fuse_strobe_o | output | 1 | Sense strobe |
| fuse_addr_o | output | 10 | Word address to the macro |

## Verification
A command write takes effect on its own clock edge. From the next cycle onward the counter equals the number of edges since that write, so the bench's pin monitor keeps its own count of edges. At each falling edge it compares every pin and the address against the windows copied at issue time. The status word is read twice: at count = largest end, where it must show busy with no flag, and one cycle later, where it must show the flag with no busy. The fuse stub adds the monitor's count to a per-address value. The captured word therefore shows exactly which cycle was sampled, and it must equal the base value plus the strobe end.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;
  localparam int NPIN = 5;
  localparam int P_CS = 0;
  localparam int P_PGEN = 1;
  localparam int P_LOAD = 2;
  localparam int P_AEN = 3;
  localparam int P_STB = 4;
  localparam int WIN_W = 16;

  localparam logic [7:0] OFF_MODE  = 8'h00;
  localparam logic [7:0] OFF_CMD   = 8'h04;
  localparam logic [7:0] OFF_STAT  = 8'h08;
  localparam logic [7:0] OFF_DOUT  = 8'h0C;
  localparam logic [7:0] OFF_BURN0 = 8'h28;
  localparam logic [7:0] OFF_READ0 = 8'h3C;

  typedef struct packed {
    logic [WIN_W-1:0] start;
    logic [WIN_W-1:0] stop;
  } win_t;

  function automatic win_t rd_default(int idx);
    win_t w;
    case (idx)
      P_AEN:   begin w.start = 16'd2; w.stop = 16'd10; end
      P_STB:   begin w.start = 16'd5; w.stop = 16'd8;  end
      default: begin w.start = 16'd0; w.stop = 16'd11; end
    endcase
    return w;
  endfunction
endpackage

// File: rtl/fuse_seq_regs.sv
module fuse_seq_regs
  import fuse_seq_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int ADDR_LSB = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              user_mode_o,
  output win_t [NPIN-1:0]   rd_win_o,
  output logic              cmd_stb_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              cap_i,
  input  logic [31:0]       cap_data_i
);
  logic        mode_q;
  logic        fin_q;
  logic [31:0] dout_q;
  win_t        rd_q   [NPIN];
  win_t        burn_q [NPIN];
  logic        clr_fin;

  assign clr_fin     = bus_we_i && (bus_addr_i == OFF_STAT) && bus_wdata_i[0];
  assign cmd_stb_o   = bus_we_i && (bus_addr_i == OFF_CMD) && (bus_wdata_i[1:0] == 2'b11);
  assign cmd_addr_o  = bus_wdata_i[ADDR_LSB +: ADDR_W];
  assign user_mode_o = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b1;
    else if (bus_we_i && bus_addr_i == OFF_MODE) mode_q <= bus_wdata_i[0];
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rd_q[i] <= rd_default(i);
      else if (bus_we_i && bus_addr_i == OFF_READ0 + 8'(4 * i)) rd_q[i] <= bus_wdata_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) burn_q[i] <= '0;
      else if (bus_we_i && bus_addr_i == OFF_BURN0 + 8'(4 * i)) burn_q[i] <= bus_wdata_i;
    end
    assign rd_win_o[i] = rd_q[i];
  end

  // completion wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fin_q <= 1'b0;
    else if (done_i)  fin_q <= 1'b1;
    else if (clr_fin) fin_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dout_q <= '0;
    else if (cap_i) dout_q <= cap_data_i;
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFF_MODE: bus_rdata_o = {31'b0, mode_q};
      OFF_STAT: bus_rdata_o = {30'b0, busy_i, fin_q};
      OFF_DOUT: bus_rdata_o = dout_q;
      default:  ;
    endcase
    for (int i = 0; i < NPIN; i++) begin
      if (bus_addr_i == OFF_READ0 + 8'(4 * i)) bus_rdata_o = rd_q[i];
      if (bus_addr_i == OFF_BURN0 + 8'(4 * i)) bus_rdata_o = burn_q[i];
    end
  end

  a_r8_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_fin && !done_i) |=> !fin_q);
endmodule

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
  import fuse_seq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cmd_stb_i,
  input  logic [ADDR_W-1:0]           cmd_addr_i,
  input  logic                        user_mode_i,
  input  logic [NPIN-1:0][WIN_W-1:0]  stop_i,
  output logic                        busy_o,
  output logic [WIN_W-1:0]            cnt_o,
  output logic [ADDR_W-1:0]           addr_o,
  output logic                        done_o,
  output logic                        cap_o
);
  logic              busy_q;
  logic [WIN_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WIN_W-1:0]  max_end;
  logic              accept;

  always_comb begin
    max_end = '0;
    for (int i = 0; i < NPIN; i++)
      if (stop_i[i] > max_end) max_end = stop_i[i];
  end

  assign accept = cmd_stb_i && !user_mode_i && !busy_q;
  assign done_o = busy_q && (cnt_q >= max_end);
  assign cap_o  = busy_q && (cnt_q == stop_i[P_STB]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      addr_q <= cmd_addr_i;
    end else if (busy_q) begin
      if (done_o) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
  assign addr_o = addr_q;

  a_r4_count_from_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (cnt_q == '0));
  a_r6_ends_after_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q >= max_end) |=> !busy_q);
  a_r9_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> (!busy_q || $stable(addr_q)));
  a_r10_no_start_user: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (user_mode_i && !busy_q) |=> !busy_q);
endmodule

// File: rtl/fuse_seq_pins.sv
module fuse_seq_pins
  import fuse_seq_pkg::*;
(
  input  logic             busy_i,
  input  logic             user_mode_i,
  input  logic [WIN_W-1:0] cnt_i,
  input  win_t [NPIN-1:0]  win_i,
  output logic [NPIN-1:0]  pins_o
);
  logic run;
  assign run = busy_i && !user_mode_i;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign pins_o[i] = run && (cnt_i >= win_i[i].start) && (cnt_i < win_i[i].stop);
  end
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_seq_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int ADDR_LSB = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [31:0]       fuse_data_i,
  output logic              fuse_cs_o,
  output logic              fuse_pgen_o,
  output logic              fuse_load_o,
  output logic              fuse_aen_o,
  output logic              fuse_strobe_o,
  output logic [ADDR_W-1:0] fuse_addr_o
);
  logic                       user_mode;
  win_t [NPIN-1:0]            rd_win;
  logic [NPIN-1:0][WIN_W-1:0] stops;
  logic                       cmd_stb;
  logic [ADDR_W-1:0]          cmd_addr;
  logic                       busy, done, cap;
  logic [WIN_W-1:0]           cnt;
  logic [NPIN-1:0]            pins;

  for (genvar i = 0; i < NPIN; i++) begin : g_stop
    assign stops[i] = rd_win[i].stop;
  end

  fuse_seq_regs #(.ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .user_mode_o(user_mode), .rd_win_o(rd_win),
    .cmd_stb_o(cmd_stb), .cmd_addr_o(cmd_addr),
    .busy_i(busy), .done_i(done), .cap_i(cap), .cap_data_i(fuse_data_i)
  );

  fuse_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_stb_i(cmd_stb), .cmd_addr_i(cmd_addr), .user_mode_i(user_mode),
    .stop_i(stops), .busy_o(busy), .cnt_o(cnt), .addr_o(fuse_addr_o),
    .done_o(done), .cap_o(cap)
  );

  fuse_seq_pins u_pins (
    .busy_i(busy), .user_mode_i(user_mode), .cnt_i(cnt),
    .win_i(rd_win), .pins_o(pins)
  );

  assign fuse_cs_o     = pins[P_CS];
  assign fuse_pgen_o   = pins[P_PGEN];
  assign fuse_load_o   = pins[P_LOAD];
  assign fuse_aen_o    = pins[P_AEN];
  assign fuse_strobe_o = pins[P_STB];

  a_r10_idle_pins_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (pins == '0));
  a_r7_capture_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |-> busy);
endmodule

// File: tb/tb_fuse_rd_seq.sv
module tb_fuse_rd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] fdata;
  logic        cs, pgen, load, aen, stb;
  logic [9:0]  faddr;

  int n_chk = 0;
  int n_fail = 0;
  int k_mon = 0;
  bit active = 1'b0;

  typedef struct packed {
    logic [9:0]       a;
    logic [4:0][15:0] s;
    logic [4:0][15:0] e;
  } item_t;

  item_t            q[$];
  item_t            cur;
  logic [4:0][15:0] win_s, win_e;

  always #4 clk = ~clk;

  fuse_rd_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .fuse_data_i(fdata),
    .fuse_cs_o(cs), .fuse_pgen_o(pgen), .fuse_load_o(load),
    .fuse_aen_o(aen), .fuse_strobe_o(stb), .fuse_addr_o(faddr)
  );

  function automatic logic [31:0] fmodel(logic [9:0] a);
    return {a, ~a, a[5:0], 6'h2A};
  endfunction

  // stub: value tagged with current count so the sampled cycle is visible
  assign fdata = fmodel(faddr) + 32'(k_mon);

  function automatic int maxe(logic [4:0][15:0] e);
    int m = 0;
    for (int i = 0; i < 5; i++) if (int'(e[i]) > m) m = int'(e[i]);
    return m;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_win(int i, logic [15:0] s, logic [15:0] e);
    bus_wr(8'h3C + 8'(4 * i), {s, e});
    win_s[i] = s;
    win_e[i] = e;
  endtask

  task automatic issue(logic [9:0] a, logic [1:0] ctl, bit acc);
    @(negedge clk);
    we = 1'b1; addr = 8'h04; wdata = {16'b0, a, 4'b0, ctl};
    @(posedge clk);
    if (acc) q.push_back('{a: a, s: win_s, e: win_e});
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_done(logic [9:0] a, int k_now);
    logic [31:0] d;
    int m = maxe(win_e);
    repeat (m - k_now) @(negedge clk);
    bus_rd(8'h08, d);
    check("R6 busy, no flag at count=max", d, 32'h2);
    @(negedge clk);
    bus_rd(8'h08, d);
    check("R6 flag set one cycle later", d, 32'h1);
    bus_rd(8'h0C, d);
    check("R7 capture at strobe end", d, fmodel(a) + 32'(win_e[4]));
    bus_wr(8'h08, 32'h0);
    bus_rd(8'h08, d);
    check("R8 write 0 keeps flag", d, 32'h1);
    bus_wr(8'h08, 32'h1);
    bus_rd(8'h08, d);
    check("R8 write 1 clears flag", d, 32'h0);
  endtask

  // monitor: compare pins against the popped item each cycle
  initial begin
    forever begin
      @(negedge clk);
      if (active) begin
        if (k_mon == maxe(cur.e)) active = 1'b0;
        else k_mon++;
      end
      if (!active && q.size() > 0) begin
        cur = q.pop_front();
        active = 1'b1;
        k_mon = 0;
      end
      if (rst_n) begin
        if (active) begin
          logic [4:0] exp;
          for (int i = 0; i < 5; i++)
            exp[i] = (k_mon >= int'(cur.s[i])) && (k_mon < int'(cur.e[i]));
          check("R4 pin windows", {27'b0, stb, aen, load, pgen, cs}, {27'b0, exp});
          check("R5 address held", {22'b0, faddr}, {22'b0, cur.a});
        end else begin
          check("R10 pins low when idle", {27'b0, stb, aen, load, pgen, cs}, 32'h0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 5; i++) begin
      win_s[i] = (i == 3) ? 16'd2 : (i == 4) ? 16'd5 : 16'd0;
      win_e[i] = (i == 3) ? 16'd10 : (i == 4) ? 16'd8 : 16'd11;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(8'h00, d); check("R1 mode resets to user", d, 32'h1);
    bus_rd(8'h08, d); check("R1 status zero", d, 32'h0);
    bus_rd(8'h3C, d); check("R1 select window", d, 32'h0000000B);
    bus_rd(8'h44, d); check("R1 load window", d, 32'h0000000B);
    bus_rd(8'h48, d); check("R1 address window", d, 32'h0002000A);
    bus_rd(8'h4C, d); check("R1 strobe window", d, 32'h00050008);

    // R10 user mode ignores commands
    issue(10'h155, 2'b11, 1'b0);
    repeat (15) @(negedge clk);
    bus_rd(8'h08, d); check("R10 no run in user mode", d, 32'h0);

    // default read, auto mode
    bus_wr(8'h00, 32'h0);
    issue(10'h155, 2'b11, 1'b1);
    bus_rd(8'h08, d); check("R3 busy visible", d, 32'h2);
    wait_done(10'h155, 0);

    // R3 both control bits required
    issue(10'h0AA, 2'b10, 1'b0);
    issue(10'h0AA, 2'b01, 1'b0);
    repeat (15) @(negedge clk);
    bus_rd(8'h08, d); check("R3 partial command ignored", d, 32'h0);

    // R9 custom windows, second command during run
    set_win(0, 16'd1, 16'd20);
    set_win(1, 16'd3, 16'd6);
    set_win(2, 16'd0, 16'd2);
    set_win(3, 16'd4, 16'd18);
    set_win(4, 16'd10, 16'd12);
    bus_rd(8'h48, d); check("R2 read window readback", d, 32'h00040012);
    issue(10'h3FF, 2'b11, 1'b1);
    repeat (2) @(negedge clk);
    issue(10'h001, 2'b11, 1'b0);
    wait_done(10'h3FF, 4);

    // R2 burn windows stored, no effect on pins
    for (int i = 0; i < 5; i++) bus_wr(8'h28 + 8'(4 * i), 32'hA5000000 + 32'(i));
    for (int i = 0; i < 5; i++) begin
      bus_rd(8'h28 + 8'(4 * i), d);
      check("R2 burn window readback", d, 32'hA5000000 + 32'(i));
    end

    // R4 empty window, strobe-driven completion
    set_win(0, 16'd0, 16'd5);
    set_win(1, 16'd7, 16'd3);
    set_win(2, 16'd0, 16'd5);
    set_win(3, 16'd0, 16'd5);
    set_win(4, 16'd2, 16'd30);
    issue(10'h000, 2'b11, 1'b1);
    wait_done(10'h000, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule